// File: doc/BRIEF.md
# Power-Up Mode and Divider Configuration Sequencer

This block brings a programmable clock generator from power-on reset to a running, configured state. When reset is released, it samples the level of the shared I/O pin through a synchronizer and uses it as a strap. A high level selects programming mode. A low level selects operating mode. The choice is latched once and holds until the next reset.

In both modes the block first loads the divider with its slowest settings. It then counts a fixed number of oscillator clocks so the oscillator can settle. In operating mode it then copies the stored mode and divisor words from the non-volatile register file into the divider, pulses the divider load and enables the clock output. In programming mode it never enables the output. It raises a hand-off flag, which releases the pin to the serial programming interface.

The block also decodes the active settings into the total division ratio that the divider applies.

Top module: `cfg_seq_top`

## Requirements
- R1: While reset is asserted and until the third rising edge after its release: `out_en_o`, `prog_mode_o` and `div_load_o` are 0, `mux_o` is 0x019, `div_o` is 0x1FF and `ratio_o` is 2052.
- R2: The mode strap is the level of `pin_i` at the first rising edge after reset release. The level passes through two synchronizer stages and is latched at the third edge. A 1 selects programming mode and a 0 selects operating mode.
- R3: In the cycle after the third edge, `div_load_o` is 1 for exactly one cycle with the maximum settings: mux word 0x019 (prescaler on, divide by 4, bypass off) and divisor word 0x1FF.
- R4: The settling wait lasts 1024 clock cycles. `div_load_o`, `out_en_o` and `prog_mode_o` stay 0 from the fourth edge up to and including edge 1028.
- R5: In operating mode, after edge 1029, `mux_o` and `div_o` equal `nv_mux_i` and `nv_div_i`, and `div_load_o` is 1 for exactly one cycle.
- R6: In operating mode, `out_en_o` becomes 1 after edge 1030, never before that, and stays 1 until reset.
- R7: In programming mode, `prog_mode_o` becomes 1 after edge 1029 and stays 1 until reset. In that mode, `out_en_o` stays 0, no second load pulse occurs, and the settings stay at maximum.
- R8: `ratio_o` decodes the active settings. Mux bit 1 set gives a ratio of 1. Otherwise the ratio is (divisor + 2), multiplied by 1 when mux bit 0 is 0. When mux bit 0 is 1, the multiplier is 2 if mux bit 2 is 1 and 4 if mux bit 2 is 0.
- R9: Once the strap is latched, changes on `pin_i` have no effect. Once the load is done, changes on `nv_mux_i` and `nv_div_i` have no effect on `mux_o`, `div_o`, `ratio_o`, `out_en_o` or `prog_mode_o`.
- R10: The factory default words (mux 0x034, divisor 0x000) give a ratio of 2 in operating mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pin_i | input | 1 | Level of the shared I/O pin, used as the mode strap |
| nv_mux_i | input | 9 | Stored mode word from the register file |
| nv_div_i | input | 9 | Stored divisor word from the register file |
| div_load_o | output | 1 | One-cycle load strobe to the divider |
| mux_o | output | 9 | Active mode word |
| div_o | output | 9 | Active divisor word |
| ratio_o | output | 12 | Decoded total division ratio |
| out_en_o | output | 1 | Clock output enable (pin driven as output) |
| prog_mode_o | output | 1 | Pin released; serial programming interface in control |

## Verification
The bench counts edges from reset release and probes the boundaries at the third edge and at edges 1028, 1029 and 1030. An off-by-one in the synchronizer depth or in the settling count shows up as a load pulse or an output enable one cycle early or late. Random stored words sweep every prescaler and bypass combination. Directed cases cover the factory defaults, the all-ones divisor and the bypass bit, so a wrong bit position or ratio formula gives a wrong `ratio_o`. After each sequence completes, the bench toggles the pin and rewrites the stored words. A design that re-samples the strap or keeps tracking the register file would then change mode, drop the enable or show new settings.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int unsigned WORD_W = 9;

  // mode word bit positions
  localparam int unsigned BIT_PRESC_EN = 0;
  localparam int unsigned BIT_BYPASS   = 1;
  localparam int unsigned BIT_M_HALF   = 2;

  // slowest settings: prescaler on, divide by 4, fixed bits 4:3 set
  localparam logic [WORD_W-1:0] MUX_MAX = 9'h019;
  localparam logic [WORD_W-1:0] DIV_MAX = 9'h1FF;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_FORCE,
    ST_SETTLE,
    ST_LOAD,
    ST_RUN,
    ST_PROG
  } seq_state_e;
endpackage

// File: rtl/cfg_strap_sync.sv
module cfg_strap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q[i] <= 1'b0;
      end else begin
        if (i == 0) ff_q[i] <= d_i;
        else        ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
  parameter int unsigned CYCLES = 1024,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (!done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == CNT_W'(CYCLES));
endmodule

// File: rtl/cfg_ratio_dec.sv
module cfg_ratio_dec #(
  parameter int unsigned WORD_W = 9,
  localparam int unsigned RATIO_W = WORD_W + 3
) (
  input  logic              presc_en_i,
  input  logic              m_half_i,
  input  logic              bypass_i,
  input  logic [WORD_W-1:0] n_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] n_eff;

  always_comb begin
    n_eff = RATIO_W'(n_i) + RATIO_W'(2);
    if (bypass_i)        ratio_o = RATIO_W'(1);
    else if (!presc_en_i) ratio_o = n_eff;
    else if (m_half_i)    ratio_o = n_eff << 1;
    else                  ratio_o = n_eff << 2;
  end
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned SETTLE_CYCLES = 1024,
  localparam int unsigned RATIO_W = WORD_W + 3,
  localparam int unsigned FILL_W  = $clog2(SYNC_STAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [WORD_W-1:0] nv_mux_i,
  input  logic [WORD_W-1:0] nv_div_i,
  output logic              div_load_o,
  output logic [WORD_W-1:0] mux_o,
  output logic [WORD_W-1:0] div_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic              out_en_o,
  output logic              prog_mode_o
);
  seq_state_e        state_q;
  logic [FILL_W-1:0] fill_q;
  logic              strap_q;
  logic              pin_sync;
  logic              settle_done;
  logic [WORD_W-1:0] mux_q, div_q;

  cfg_strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  cfg_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_SETTLE),
    .done_o(settle_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FILL;
      fill_q  <= '0;
      strap_q <= 1'b0;
      mux_q   <= MUX_MAX;
      div_q   <= DIV_MAX;
    end else begin
      unique case (state_q)
        ST_FILL: begin
          if (fill_q == FILL_W'(SYNC_STAGES)) begin
            strap_q <= pin_sync; // latched once per power-up
            state_q <= ST_FORCE;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
        end
        ST_FORCE: begin
          mux_q   <= MUX_MAX;
          div_q   <= DIV_MAX;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_done) begin
            if (strap_q) begin
              state_q <= ST_PROG;
            end else begin
              mux_q   <= nv_mux_i;
              div_q   <= nv_div_i;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_LOAD:  state_q <= ST_RUN;
        ST_RUN:   state_q <= ST_RUN;
        ST_PROG:  state_q <= ST_PROG;
        default:  state_q <= ST_FILL;
      endcase
    end
  end

  cfg_ratio_dec #(.WORD_W(WORD_W)) u_dec (
    .presc_en_i(mux_q[BIT_PRESC_EN]),
    .m_half_i  (mux_q[BIT_M_HALF]),
    .bypass_i  (mux_q[BIT_BYPASS]),
    .n_i       (div_q),
    .ratio_o   (ratio_o)
  );

  assign div_load_o  = (state_q == ST_FORCE) || (state_q == ST_LOAD);
  assign out_en_o    = (state_q == ST_RUN);
  assign prog_mode_o = (state_q == ST_PROG);
  assign mux_o       = mux_q;
  assign div_o       = div_q;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int unsigned WORD_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_load_o,
  input logic [WORD_W-1:0] mux_o,
  input logic [WORD_W-1:0] div_o,
  input logic              out_en_o,
  input logic              prog_mode_o
);
  a_r7_mode_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_en_o && prog_mode_o));

  a_r7_prog_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_mode_o |=> prog_mode_o);

  a_r6_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |=> out_en_o);

  a_r5_load_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_o |=> !div_load_o);

  a_r6_en_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $past(div_load_o));

  a_r9_hold_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o || prog_mode_o) |=> ($stable(mux_o) && $stable(div_o) && !div_load_o));
endmodule

bind cfg_seq_top cfg_seq_chk #(.WORD_W(cfg_seq_pkg::WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_load_o (div_load_o),
  .mux_o      (mux_o),
  .div_o      (div_o),
  .out_en_o   (out_en_o),
  .prog_mode_o(prog_mode_o)
);

// File: tb/sim_cfg_seq_top.sv
module sim_cfg_seq_top;
  localparam int SETTLE = 1024;
  localparam int E_FORCE = 3;
  localparam int E_DONE  = SETTLE + 5;   // 1029
  localparam int E_RUN   = SETTLE + 6;   // 1030

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0;
  logic [8:0]  nv_mux_i = '0, nv_div_i = '0;
  logic        div_load_o, out_en_o, prog_mode_o;
  logic [8:0]  mux_o, div_o;
  logic [11:0] ratio_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  cfg_seq_top u0 (
    .clk_i, .rst_ni, .pin_i, .nv_mux_i, .nv_div_i,
    .div_load_o, .mux_o, .div_o, .ratio_o, .out_en_o, .prog_mode_o
  );

  function automatic int ratio_ref(logic [8:0] m, logic [8:0] d);
    int n = int'(d) + 2;
    if (m[1]) return 1;
    if (!m[0]) return n;
    return m[2] ? 2 * n : 4 * n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic power_up(logic strap, logic [8:0] m, logic [8:0] d);
    int exp_ratio = ratio_ref(m, d);
    rst_ni = 1'b0;
    pin_i = strap;
    nv_mux_i = m;
    nv_div_i = d;
    edges(3);
    // R1 reset state
    check("R1 en", out_en_o, 0);
    check("R1 prog", prog_mode_o, 0);
    check("R1 load", div_load_o, 0);
    check("R1 mux", mux_o, 9'h019);
    check("R1 div", div_o, 9'h1FF);
    check("R1 ratio", ratio_o, 2052);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edges(E_FORCE - 1);
    check("R1 load before edge3", div_load_o, 0);
    edges(1);
    // R3 max load pulse
    check("R3 load", div_load_o, 1);
    check("R3 mux", mux_o, 9'h019);
    check("R3 div", div_o, 9'h1FF);
    check("R3 ratio", ratio_o, 2052);
    pin_i = ~strap; // R9 strap already latched
    edges(1);
    check("R3 single", div_load_o, 0);
    edges(E_DONE - 1 - (E_FORCE + 1));
    // edge 1028: still settling
    check("R4 load", div_load_o, 0);
    check("R4 en", out_en_o, 0);
    check("R4 prog", prog_mode_o, 0);
    edges(1);
    if (!strap) begin
      check("R5 load", div_load_o, 1);
      check("R5 mux", mux_o, m);
      check("R5 div", div_o, d);
      check("R6 early", out_en_o, 0);
      check("R8 ratio", ratio_o, exp_ratio);
      edges(1);
      check("R6 en", out_en_o, 1);
      check("R5 single", div_load_o, 0);
    end else begin
      check("R7 prog", prog_mode_o, 1);
      check("R7 en", out_en_o, 0);
      check("R7 load", div_load_o, 0);
      check("R7 mux", mux_o, 9'h019);
      edges(1);
      check("R7 prog hold", prog_mode_o, 1);
    end
    // R9 later input changes ignored
    pin_i = $urandom();
    nv_mux_i = $urandom();
    nv_div_i = $urandom();
    edges(17);
    pin_i = ~pin_i;
    edges(5);
    check("R9 en", out_en_o, strap ? 0 : 1);
    check("R9 prog", prog_mode_o, strap ? 1 : 0);
    check("R9 mux", mux_o, strap ? 9'h019 : m);
    check("R9 div", div_o, strap ? 9'h1FF : d);
    check("R9 ratio", ratio_o, strap ? 2052 : exp_ratio);
    check("R2 mode", prog_mode_o, int'(strap));
  endtask

  initial begin
    void'($urandom(32'h5eed_1065));
    // R10 factory defaults
    power_up(1'b0, 9'h034, 9'h000);
    check("R10 ratio", ratio_o, 2);
    // R8 directed corners
    power_up(1'b0, 9'h01B, 9'h1FF); // bypass wins
    power_up(1'b0, 9'h019, 9'h1FF); // /4 * 513
    power_up(1'b0, 9'h01D, 9'h000); // /2 * 2
    // R2 R7 programming strap
    power_up(1'b1, 9'h034, 9'h055);
    for (int i = 0; i < 6; i++) begin
      logic [8:0] m = 9'h018 | 9'($urandom_range(0, 7));
      power_up(1'($urandom_range(0, 1)), m, 9'($urandom()));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule